// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block services a ring of transmit descriptors kept in host memory. A one-cycle polling demand starts a walk: the block fetches the descriptor at its current ring position. If the host has handed that descriptor over, the block reads the buffer it points to byte by byte and streams those bytes out. It then writes the descriptor's status back and hands the entry back to the host. The walk moves on to the next entry and ends at the first entry the host still holds. One frame may span several chained descriptors, which are marked by start and end flags.

At the end of each frame the block can pad the frame to the minimum length. It caps frames at the maximum length and notes either event in the descriptor status. It also flags frames whose destination matches one of its own station addresses. Frames go either to the transmit side or, in internal loopback, to the receive queue. A per-byte route bit and a frame-done pulse tell the consumer which. Frame, payload-byte and aborted-frame counters saturate. CRC and medium access are handled elsewhere.

Top module: `txring_gather`

## Requirements
- R1: Memory access uses `mem_req` held with a stable address, direction and write data until `mem_ack`. The read data and `mem_err` are valid in the ack cycle. Descriptor words are 16-bit little-endian accesses, and buffer data is read one byte at a time (`mem_byte`=1, byte in `mem_rdata[7:0]`), never written.
- R2: A `poll` pulse starts a walk at the current ring index. Descriptor i starts at `ring_base + 2*entry_len*i`. Its words are: +0 buffer byte length, +2 buffer address bits 15:0, +4 flags with buffer address bits 17:16 in bits 1:0, +6 status. After entry `ring_count-1` the index wraps to 0, and the index persists between walks.
- R3: A descriptor whose flags bit 15 (owned by block) is clear ends the walk without being written.
- R4: Flags bit 9 (frame start) restarts the frame. Buffer bytes are emitted in address order, chained descriptors append, and at most MAXF (1514) bytes are emitted; any excess is dropped and the frame is marked giant.
- R5: On a descriptor with flags bit 8 (frame end), if `mode_pad` is set and the frame is shorter than 60 bytes, zero bytes are emitted up to 60 and the frame is marked runt.
- R6: When `mode_loop` and `mode_intl` are both set, every byte carries `out_loop`=1 and the frame ends with `fr_loop`=1; otherwise both are 0.
- R7: On the frame-end descriptor, a giant or runt frame sets status bit 15 (length error) and flags bit 14 (error summary) in the write-back.
- R8: On the frame-end descriptor, if the first six frame bytes equal any station table entry, flags bit 13 is set. Entry g occupies `sta_table[48g+47:48g]`, and its first byte is in bits 7:0.
- R9: Each descriptor is written back: the status word first, then the flags word with bit 15 cleared. All other bits are preserved. The index then advances.
- R10: Each finished frame gives a one-cycle `fr_done` and `tx_int` together, with `fr_len` holding the final length. `frame_cnt` rises by 1 and `byte_cnt` by the length minus 14 (0 if shorter). Both counters saturate and are zero after reset.
- R11: A read error pulses `err_rd` and ends the walk, with no further bytes, no frame-done and no write-back. The index does not advance.
- R12: A write-back error pulses `err_wb`, increments `abort_cnt` and ends the walk without advancing the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | Polling demand pulse |
| ring_base | input | AW | Byte address of ring entry 0 |
| entry_len | input | 8 | Ring entry size in 16-bit words |
| ring_count | input | 16 | Number of ring entries |
| mode_pad | input | 1 | Pad short frames to minimum |
| mode_loop | input | 1 | Loopback mode |
| mode_intl | input | 1 | Internal loopback select |
| sta_table | input | NSTA*48 | Station address table |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_byte | output | 1 | Byte-wide read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory access error |
| mem_rdata | input | 16 | Memory read data |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_loop | output | 1 | Byte routed to receive queue |
| fr_done | output | 1 | Frame complete pulse |
| fr_len | output | clog2(MAXF+1) | Final frame length |
| fr_loop | output | 1 | Finished frame routed to receive queue |
| tx_int | output | 1 | Transmit interrupt pulse |
| err_rd | output | 1 | Read error pulse |
| err_wb | output | 1 | Write-back error pulse |
| frame_cnt | output | CW | Frames sent |
| byte_cnt | output | CW | Payload bytes sent |
| abort_cnt | output | 16 | Aborted frames |

## Verification
A stale ring offset would make the very next flags read go to the wrong address. No bytes would then stream, and the host's descriptor would keep its ownership bit, which is visible as soon as the walk stops. A wrong frame length or giant/runt state would show in the stream as an extra or missing byte the cycle it is emitted. It would also show at `fr_done` and in the status words written back a few cycles later. A missed frame-start reset would carry the previous length into the next frame, and would be caught on its first byte count mismatch.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int FLG_OWN  = 15;
  localparam int FLG_ERRS = 14;
  localparam int FLG_MTCH = 13;
  localparam int FLG_STF  = 9;
  localparam int FLG_ENF  = 8;
  localparam int ST_BUFL  = 15;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLG, S_RD_LEN, S_RD_BUF, S_RD_ST3, S_DATA,
    S_CHK, S_PAD, S_FIN, S_WB_ST3, S_WB_FLG
  } txr_state_e;
endpackage

// File: rtl/txr_ring_pos.sv
module txr_ring_pos #(
  parameter int AW = 18,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] stride,
  input  logic [IW-1:0] count,
  output logic [AW-1:0] off
);
  logic [IW-1:0] idx;
  logic [IW:0]   nxt;

  assign nxt = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      off <= '0;
    end else if (adv) begin
      if (nxt >= {1'b0, count}) begin
        idx <= '0;
        off <= '0;
      end else begin
        idx <= nxt[IW-1:0];
        off <= off + stride;
      end
    end
  end
endmodule

// File: rtl/txr_sta_match.sv
module txr_sta_match #(
  parameter int NSTA = 4
) (
  input  logic [47:0]        dst,
  input  logic [NSTA*48-1:0] tbl,
  output logic               hit
);
  logic [NSTA-1:0] eq;

  for (genvar g = 0; g < NSTA; g++) begin : g_cmp
    assign eq[g] = (tbl[g*48 +: 48] == dst);
  end

  assign hit = |eq;
endmodule

// File: rtl/txr_sat_cnt.sv
module txr_sat_cnt #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  logic [W:0] sum;

  assign sum = {1'b0, cnt} + (W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/txring_gather.sv
module txring_gather
  import txr_pkg::*;
#(
  parameter int AW   = 18,
  parameter int MAXF = 1514,
  parameter int MINF = 60,
  parameter int HDR  = 14,
  parameter int NSTA = 4,
  parameter int CW   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       poll,
  input  logic [AW-1:0]              ring_base,
  input  logic [7:0]                 entry_len,
  input  logic [15:0]                ring_count,
  input  logic                       mode_pad,
  input  logic                       mode_loop,
  input  logic                       mode_intl,
  input  logic [NSTA*48-1:0]         sta_table,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic                       mem_byte,
  output logic [AW-1:0]              mem_addr,
  output logic [15:0]                mem_wdata,
  input  logic                       mem_ack,
  input  logic                       mem_err,
  input  logic [15:0]                mem_rdata,
  output logic                       out_valid,
  output logic [7:0]                 out_data,
  output logic                       out_loop,
  output logic                       fr_done,
  output logic [$clog2(MAXF+1)-1:0]  fr_len,
  output logic                       fr_loop,
  output logic                       tx_int,
  output logic                       err_rd,
  output logic                       err_wb,
  output logic [CW-1:0]              frame_cnt,
  output logic [CW-1:0]              byte_cnt,
  output logic [15:0]                abort_cnt
);
  localparam int LW = $clog2(MAXF+1);

  txr_state_e    st;
  logic [15:0]   w0, w1, w2, w3, w2_ret;
  logic [LW-1:0] flen, wlen, k, pay;
  logic          giant, runt, hit, route, adv, ack_ok, ack_bad, wb_bad;
  logic [47:0]   dst;
  logic [AW-1:0] d_off, d_base, s_base;
  logic [16:0]   room, take;

  assign route  = mode_loop & mode_intl;
  assign ack_ok = mem_req & mem_ack & ~mem_err;
  assign ack_bad = mem_req & mem_ack & mem_err;
  assign wb_bad = ack_bad & mem_we;
  assign adv    = (st == S_WB_FLG) & ack_ok;
  assign d_base = ring_base + d_off;
  assign s_base = AW'({w2[1:0], w1});
  assign room   = 17'(MAXF) - 17'(flen);
  assign take   = ({1'b0, w0} > room) ? room : {1'b0, w0};
  assign pay    = (flen >= LW'(HDR)) ? flen - LW'(HDR) : '0;

  txr_ring_pos #(.AW(AW), .IW(16)) u_pos (
    .clk(clk), .rst(rst), .adv(adv),
    .stride(AW'({entry_len, 1'b0})), .count(ring_count), .off(d_off)
  );

  txr_sta_match #(.NSTA(NSTA)) u_match (.dst(dst), .tbl(sta_table), .hit(hit));

  txr_sat_cnt #(.W(CW), .IW(1)) u_frames (
    .clk(clk), .rst(rst), .en(st == S_FIN), .inc(1'b1), .cnt(frame_cnt)
  );
  txr_sat_cnt #(.W(CW), .IW(LW)) u_bytes (
    .clk(clk), .rst(rst), .en(st == S_FIN), .inc(pay), .cnt(byte_cnt)
  );
  txr_sat_cnt #(.W(16), .IW(1)) u_aborts (
    .clk(clk), .rst(rst), .en(wb_bad), .inc(1'b1), .cnt(abort_cnt)
  );

  always_comb begin
    w2_ret = w2;
    w2_ret[FLG_OWN] = 1'b0;
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_wdata = 16'h0000;
    mem_addr  = d_base;
    case (st)
      S_RD_FLG: mem_addr = d_base + AW'(4);
      S_RD_LEN: mem_addr = d_base;
      S_RD_BUF: mem_addr = d_base + AW'(2);
      S_RD_ST3: mem_addr = d_base + AW'(6);
      S_DATA: begin
        mem_addr = s_base + AW'(k);
        mem_byte = 1'b1;
      end
      S_WB_ST3: begin
        mem_addr  = d_base + AW'(6);
        mem_we    = 1'b1;
        mem_wdata = w3;
      end
      S_WB_FLG: begin
        mem_addr  = d_base + AW'(4);
        mem_we    = 1'b1;
        mem_wdata = w2_ret;
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      {w0, w1, w2, w3} <= '0;
      {flen, wlen, k} <= '0;
      {giant, runt} <= 2'b00;
      dst <= '0;
      {out_valid, out_loop, fr_done, fr_loop, tx_int, err_rd, err_wb} <= '0;
      out_data <= '0;
      fr_len <= '0;
    end else begin
      out_valid <= 1'b0;
      fr_done   <= 1'b0;
      tx_int    <= 1'b0;
      err_rd    <= ack_bad & ~mem_we;
      err_wb    <= wb_bad;
      if (ack_bad) st <= S_IDLE;
      else case (st)
        S_IDLE: if (poll) st <= S_RD_FLG;
        S_RD_FLG: if (ack_ok) begin
          w2 <= mem_rdata;
          if (!mem_rdata[FLG_OWN]) st <= S_IDLE;
          else begin
            if (mem_rdata[FLG_STF]) begin
              flen <= '0; giant <= 1'b0; runt <= 1'b0; dst <= '0;
            end
            st <= S_RD_LEN;
          end
        end
        S_RD_LEN: if (ack_ok) begin w0 <= mem_rdata; st <= S_RD_BUF; end
        S_RD_BUF: if (ack_ok) begin w1 <= mem_rdata; st <= S_RD_ST3; end
        S_RD_ST3: if (ack_ok) begin
          w3   <= mem_rdata;
          k    <= '0;
          wlen <= LW'(take);
          if ({1'b0, w0} > room) giant <= 1'b1;
          st <= (take == 17'd0) ? S_CHK : S_DATA;
        end
        S_DATA: if (ack_ok) begin
          out_valid <= 1'b1;
          out_data  <= mem_rdata[7:0];
          out_loop  <= route;
          if (flen < LW'(6)) dst[{flen[2:0], 3'b000} +: 8] <= mem_rdata[7:0];
          flen <= flen + 1'b1;
          k    <= k + 1'b1;
          if (k + 1'b1 == wlen) st <= S_CHK;
        end
        S_CHK: begin
          if (!w2[FLG_ENF]) st <= S_WB_ST3;
          else if (mode_pad && flen < LW'(MINF)) begin
            runt <= 1'b1;
            st   <= S_PAD;
          end else st <= S_FIN;
        end
        S_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          out_loop  <= route;
          flen      <= flen + 1'b1;
          if (flen + 1'b1 == LW'(MINF)) st <= S_FIN;
        end
        S_FIN: begin
          fr_done <= 1'b1;
          tx_int  <= 1'b1;
          fr_len  <= flen;
          fr_loop <= route;
          if (giant | runt) begin
            w3[ST_BUFL]  <= 1'b1;
            w2[FLG_ERRS] <= 1'b1;
          end
          if (hit) w2[FLG_MTCH] <= 1'b1;
          st <= S_WB_ST3;
        end
        S_WB_ST3: if (ack_ok) st <= S_WB_FLG;
        S_WB_FLG: if (ack_ok) st <= S_RD_FLG;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R1
  AST_BYTE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_byte |-> !mem_we); // R1
  AST_GIANT_AT_CAP: assert property (@(posedge clk) disable iff (rst)
    fr_done && giant |-> fr_len == LW'(MAXF)); // R4
  AST_RUNT_AT_MIN: assert property (@(posedge clk) disable iff (rst)
    fr_done && runt |-> fr_len == LW'(MINF)); // R5
  AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !$past(mem_we) |=> !mem_ack || mem_we); // R9
  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_int |=> !tx_int); // R10
  AST_FRAMES_MONO: assert property (@(posedge clk) disable iff (rst)
    frame_cnt >= $past(frame_cnt)); // R10
endmodule

// File: tb/txring_gather_tb.sv
`timescale 1ns/1ps
module txring_gather_tb;
  localparam int AW = 18, MAXF = 1514, MINF = 60, NSTA = 4, CW = 32;
  localparam int RB = 256;
  localparam int OWN = 16'h8000, ERRS = 16'h4000, MTCH = 16'h2000;
  localparam int STF = 16'h0200, ENF = 16'h0100, BUFL = 16'h8000, HOSTST = 16'h0012;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, poll, mode_pad, mode_loop, mode_intl;
  logic [AW-1:0] ring_base;
  logic [7:0] entry_len;
  logic [15:0] ring_count;
  logic [NSTA*48-1:0] sta_table;
  logic mem_req, mem_we, mem_byte, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic out_valid, out_loop, fr_done, fr_loop, tx_int, err_rd, err_wb;
  logic [7:0] out_data;
  logic [10:0] fr_len;
  logic [CW-1:0] frame_cnt, byte_cnt;
  logic [15:0] abort_cnt;

  txring_gather u_dut (
    .clk(clk), .rst(rst), .poll(poll), .ring_base(ring_base), .entry_len(entry_len),
    .ring_count(ring_count), .mode_pad(mode_pad), .mode_loop(mode_loop),
    .mode_intl(mode_intl), .sta_table(sta_table), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_loop(out_loop), .fr_done(fr_done), .fr_len(fr_len), .fr_loop(fr_loop),
    .tx_int(tx_int), .err_rd(err_rd), .err_wb(err_wb), .frame_cnt(frame_cnt),
    .byte_cnt(byte_cnt), .abort_cnt(abort_cnt)
  );

  logic [7:0] mem [0:4095];
  int err_at = -1;
  bit err_wr_only = 1'b0;
  int total = 0, bad = 0;
  int exp_b[$];
  int exp_f[$];
  longint e_frames = 0, e_bytes = 0, e_abort = 0;
  int n_err_rd = 0, n_err_wb = 0;
  int m_len;
  bit m_giant, m_runt;
  logic [7:0] m_dst [0:5];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory responder: one ack per request, one cycle after it is seen
  always @(negedge clk) begin
    int a;
    if (mem_req && !mem_ack) begin
      a = int'(mem_addr) & 4095;
      mem_err = (a == err_at) && (mem_we || !err_wr_only);
      if (!mem_err) begin
        if (mem_we) begin
          mem[a] = mem_wdata[7:0];
          mem[(a+1) & 4095] = mem_wdata[15:8];
        end else if (mem_byte) mem_rdata = {8'h00, mem[a]};
        else mem_rdata = {mem[(a+1) & 4095], mem[a]};
      end
      mem_ack = 1'b1;
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  // reference comparison every clock
  always @(negedge clk) begin
    int e;
    if (!rst) begin
      chk(tx_int == fr_done, "R10 interrupt with frame end", tx_int, fr_done);
      if (out_valid) begin
        if (exp_b.size() == 0) chk(0, "R4 unexpected byte", out_data, -1);
        else begin
          e = exp_b.pop_front();
          chk({23'd0, out_loop, out_data} == e, "R4 R6 stream byte/route",
              {out_loop, out_data}, e);
        end
      end
      if (fr_done) begin
        if (exp_f.size() == 0) chk(0, "R10 unexpected frame", fr_len, -1);
        else begin
          e = exp_f.pop_front();
          chk({15'd0, fr_loop, 5'd0, fr_len} == e, "R10 R6 frame length/route",
              {fr_loop, 5'd0, fr_len}, e);
        end
      end
      if (err_rd) n_err_rd++;
      if (err_wb) n_err_wb++;
    end
  end

  function automatic int rd16(input int a);
    return {16'd0, mem[a+1], mem[a]};
  endfunction

  task automatic wr16(input int a, input int v);
    mem[a] = 8'(v);
    mem[a+1] = 8'(v >> 8);
  endtask

  task automatic set_desc(input int i, input int len, input int buf_a, input int flags);
    wr16(RB + 8*i, len);
    wr16(RB + 8*i + 2, buf_a);
    wr16(RB + 8*i + 4, flags);
    wr16(RB + 8*i + 6, HOSTST);
  endtask

  task automatic fill(input int a, input int n, input int seed);
    for (int j = 0; j < n; j++) mem[a+j] = 8'(seed + j*7);
  endtask

  task automatic m_start();
    m_len = 0; m_giant = 0; m_runt = 0;
    for (int j = 0; j < 6; j++) m_dst[j] = 8'h00;
  endtask

  task automatic m_seg(input int a, input int n);
    for (int j = 0; j < n; j++) begin
      if (m_len < MAXF) begin
        if (m_len < 6) m_dst[m_len] = mem[a+j];
        exp_b.push_back(((mode_loop & mode_intl) ? 256 : 0) + int'(mem[a+j]));
        m_len++;
      end else m_giant = 1;
    end
  endtask

  function automatic bit m_hit();
    bit h = 0;
    for (int g = 0; g < NSTA; g++) begin
      bit eq = 1;
      for (int j = 0; j < 6; j++) if (sta_table[g*48 + j*8 +: 8] != m_dst[j]) eq = 0;
      if (eq) h = 1;
    end
    return h;
  endfunction

  // closes the model frame; returns the flags bits added to the end descriptor
  task automatic m_end(output int add2, output int add3);
    int lp;
    lp = (mode_loop & mode_intl) ? 1 : 0;
    if (mode_pad && m_len < MINF) begin
      while (m_len < MINF) begin exp_b.push_back(lp*256); m_len++; end
      m_runt = 1;
    end
    exp_f.push_back(lp*65536 + m_len);
    e_frames++;
    e_bytes += (m_len >= 14) ? m_len - 14 : 0;
    add2 = ((m_giant || m_runt) ? ERRS : 0) | (m_hit() ? MTCH : 0);
    add3 = (m_giant || m_runt) ? BUFL : 0;
  endtask

  task automatic do_poll();
    int q;
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
    q = 0;
    while (q < 80) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
    end
  endtask

  task automatic chk_after(input string req);
    chk(exp_b.size() == 0, {req, " all bytes emitted"}, exp_b.size(), 0);
    chk(exp_f.size() == 0, {req, " all frames done"}, exp_f.size(), 0);
    chk(frame_cnt == e_frames, "R10 frame counter", frame_cnt, e_frames);
    chk(byte_cnt == e_bytes, "R10 byte counter", byte_cnt, e_bytes);
    chk(abort_cnt == e_abort, "R12 abort counter", abort_cnt, e_abort);
  endtask

  task automatic chk_desc(input int i, input int w2, input int w3, input string req);
    chk(rd16(RB + 8*i + 4) == w2, {req, " flags write-back"}, rd16(RB + 8*i + 4), w2);
    chk(rd16(RB + 8*i + 6) == w3, {req, " status write-back"}, rd16(RB + 8*i + 6), w3);
  endtask

  initial begin
    int a2, a3;
    for (int j = 0; j < 4096; j++) mem[j] = 8'h00;
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    rst = 1; poll = 0; mode_pad = 0; mode_loop = 0; mode_intl = 0;
    ring_base = AW'(RB); entry_len = 8'd4; ring_count = 16'd4;
    sta_table = {48'hC1C2C3C4C5C6, 48'h554433221102, 48'hB6B5B4B3B2B1, 48'hE0E1E2E3E4E5};
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk(mem_req == 0 && out_valid == 0, "R1 idle after reset", mem_req, 0);
    chk(frame_cnt == 0 && byte_cnt == 0 && abort_cnt == 0, "R10 counters reset", frame_cnt, 0);

    // single-descriptor frame, stop at host-owned entry
    fill(1024, 64, 16);
    set_desc(0, 64, 1024, OWN | STF | ENF);
    set_desc(1, 10, 1200, 0);
    m_start(); m_seg(1024, 64); m_end(a2, a3);
    do_poll();
    chk_after("R2");
    chk_desc(0, STF | ENF | a2, HOSTST | a3, "R9");
    chk_desc(1, 0, HOSTST, "R3");

    // chained frame padded to minimum
    mode_pad = 1;
    fill(1100, 30, 40); fill(1200, 20, 90);
    set_desc(1, 30, 1100, OWN | STF);
    set_desc(2, 20, 1200, OWN | ENF);
    set_desc(3, 5, 1300, 0);
    m_start(); m_seg(1100, 30); m_seg(1200, 20); m_end(a2, a3);
    do_poll();
    chk_after("R5");
    chk_desc(1, STF, HOSTST, "R9");
    chk_desc(2, ENF | ERRS, HOSTST | BUFL, "R7");
    chk(a2 == ERRS, "R5 model runt", a2, ERRS);

    // wrap around the ring with internal loopback, no padding
    mode_pad = 0; mode_loop = 1; mode_intl = 1;
    fill(1300, 40, 7); fill(1400, 70, 200);
    set_desc(3, 40, 1300, OWN | STF | ENF);
    set_desc(0, 70, 1400, OWN | STF | ENF);
    m_start(); m_seg(1300, 40); m_end(a2, a3);
    m_start(); m_seg(1400, 70); m_end(a2, a3);
    do_poll();
    chk_after("R6");
    chk_desc(3, STF | ENF, HOSTST, "R2");
    chk_desc(0, STF | ENF, HOSTST, "R2");

    // loop bit alone does not route to receive queue
    mode_intl = 0;
    fill(1500, 20, 33);
    set_desc(1, 20, 1500, OWN | STF | ENF);
    m_start(); m_seg(1500, 20); m_end(a2, a3);
    do_poll();
    chk_after("R6");

    // oversize frame across two descriptors
    mode_loop = 0;
    fill(1024, 1000, 3); fill(2048, 600, 11);
    set_desc(2, 1000, 1024, OWN | STF);
    set_desc(3, 600, 2048, OWN | ENF);
    m_start(); m_seg(1024, 1000); m_seg(2048, 600); m_end(a2, a3);
    do_poll();
    chk_after("R4");
    chk_desc(3, ENF | ERRS, HOSTST | BUFL, "R7");
    chk(m_len == MAXF, "R4 model cap", m_len, MAXF);

    // destination matches station table entry 2
    fill(1600, 64, 77);
    mem[1600] = 8'h02; mem[1601] = 8'h11; mem[1602] = 8'h22;
    mem[1603] = 8'h33; mem[1604] = 8'h44; mem[1605] = 8'h55;
    set_desc(0, 64, 1600, OWN | STF | ENF);
    m_start(); m_seg(1600, 64); m_end(a2, a3);
    do_poll();
    chk_after("R8");
    chk_desc(0, STF | ENF | MTCH, HOSTST, "R8");

    // read error mid-buffer, then retry of the same descriptor
    fill(1700, 20, 5);
    set_desc(1, 20, 1700, OWN | STF | ENF);
    err_at = 1705; err_wr_only = 0;
    m_start(); m_seg(1700, 5);
    do_poll();
    chk(n_err_rd == 1, "R11 read error pulse", n_err_rd, 1);
    chk_after("R11");
    chk_desc(1, OWN | STF | ENF, HOSTST, "R11");
    err_at = -1;
    m_start(); m_seg(1700, 20); m_end(a2, a3);
    do_poll();
    chk_after("R11");
    chk_desc(1, STF | ENF, HOSTST, "R11");

    // write-back error aborts the walk
    fill(1800, 20, 9);
    set_desc(2, 20, 1800, OWN | STF | ENF);
    err_at = RB + 16 + 6; err_wr_only = 1;
    m_start(); m_seg(1800, 20); m_end(a2, a3);
    e_abort++;
    do_poll();
    chk(n_err_wb == 1, "R12 write error pulse", n_err_wb, 1);
    chk_after("R12");
    chk_desc(2, OWN | STF | ENF, HOSTST, "R12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule